// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog timer on a small register bus: an address, a write strobe and 16 bits of write data. Software programs a 32-bit timeout, counted in clock cycles, by writing it as two 16-bit halves. The upper half goes in first. The value becomes usable only once the lower half has been written. The watchdog stays idle after power-up.

The count starts, or starts again, only when software writes a fixed pair of unlock words to a dedicated clear register. If the down-count expires before the next valid pair arrives, the block asserts two reset outputs together for a fixed number of cycles:

- a system reset;
- a reset drive for an expansion bus.

After the reset pulse the block returns to idle, and its programmed timeout is erased. Typical use is to program the timeout once, feed the watchdog from a periodic software task, and let it reset the system when that task stops running. Programming a zero timeout and then feeding gives an immediate software-triggered reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, both reset outputs are low and the watchdog is idle. No timeout occurs, however long the wait, until a valid feed has been accepted.
- R2: A write to offset 0x0 stages the upper 16 bits in a holding register. A write to offset 0x2 sets the timeout to {staged upper, written lower}. A write to offset 0x0 alone does not change the timeout that a later feed loads.
- R3: A feed is a write of 0xF01E to offset 0x8 followed by a write of 0x0FE1 to offset 0x8. Idle bus cycles between the two writes are allowed. A feed loads the counter with the 32-bit timeout and starts the count.
- R4: A write of 0x0FE1 to offset 0x8 is ignored unless the previous accepted write to the block was 0xF01E to offset 0x8.
- R5: A pending first word is discarded by any of the following: a write to offset 0x8 with a value other than the two keys, or a write to any address other than 0x8.
- R6: With timeout N programmed, the reset outputs rise on the (N+1)th rising clock edge after the edge that accepts the second feed word.
- R7: A timeout of zero followed by a feed raises the reset outputs on the very next rising edge.
- R8: A feed that completes while the count is running restarts the count from the full timeout. Feeding more often than the timeout keeps the outputs low.
- R9: The system reset and the bus reset drive are active high and always equal. Each timeout holds them high for exactly 16 consecutive cycles.
- R10: After the reset pulse, the block is idle again and the timeout and staged upper half are both zero. A feed with no reprogramming then times out on the next edge.
- R11: Bus writes made while the reset outputs are high are ignored. This covers reload writes and feeds alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset of the write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| sys_rst_o | output | 1 | System reset request, active high |
| bus_rst_o | output | 1 | Expansion bus reset drive, active high |

## Verification
The count path is tried with timeouts of zero, a few cycles, a few hundred cycles and one full upper-half unit. Together these separate an off-by-one in the expiry edge from a wrong half-word join. Feed sequences are tried in several forms:

- the bare second key;
- the first key followed by a foreign value;
- the first key followed by a write to another offset;
- a pair separated by idle cycles.

These distinguish strict ordering from mere presence of both keys. Restaging only the upper half before a feed shows whether a half-written value leaks into the count. Writes made during the pulse, followed by a feed after it, show whether the pulse blocks the bus and whether the programmed timeout is really cleared.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_FIRE = 2'd2
  } wd_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic clr;
    logic other;
  } wd_wr_s;

endpackage

// File: rtl/wdog_reload_regs.sv
module wdog_reload_regs #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned RELOAD_W = 2 * HALF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                wipe,
  output logic [RELOAD_W-1:0] reload_o
);

  function automatic logic [RELOAD_W-1:0] join_halves(
    input logic [HALF_W-1:0] upper,
    input logic [HALF_W-1:0] lower
  );
    return {upper, lower};
  endfunction

  logic [HALF_W-1:0]   stage_q;
  logic [RELOAD_W-1:0] reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      reload_q <= '0;
    end else if (wipe) begin
      stage_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_hi) stage_q  <= wdata;
      if (wr_lo) reload_q <= join_halves(stage_q, wdata);
    end
  end

  assign reload_o = reload_q;

endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq #(
  parameter int unsigned HALF_W = 16,
  parameter logic [HALF_W-1:0] KEY_FIRST  = 'hF01E,
  parameter logic [HALF_W-1:0] KEY_SECOND = 'h0FE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_clr,
  input  logic              wr_other,
  input  logic [HALF_W-1:0] wdata,
  input  logic              wipe,
  output logic              feed_o
);

  logic armed_q;
  logic is_first;
  logic is_second;

  assign is_first  = (wdata == KEY_FIRST);
  assign is_second = (wdata == KEY_SECOND);
  assign feed_o    = wr_clr && is_second && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wipe || wr_other) begin
      armed_q <= 1'b0;
    end else if (wr_clr) begin
      armed_q <= is_first;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned RELOAD_W  = 32,
  parameter int unsigned PULSE_CYC = 16,
  localparam int unsigned PULSE_W  = $clog2(PULSE_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                feed,
  input  logic [RELOAD_W-1:0] reload,
  output logic                timeout_o,
  output logic                firing_o,
  output logic                fire_done_o
);

  function automatic logic [RELOAD_W-1:0] count_down(input logic [RELOAD_W-1:0] c);
    return c - RELOAD_W'(1);
  endfunction

  wd_state_e           state_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic [PULSE_W-1:0]  pulse_q;

  assign timeout_o   = (state_q == WD_RUN) && (cnt_q == '0) && !feed;
  assign fire_done_o = (state_q == WD_FIRE) && (pulse_q == PULSE_W'(PULSE_CYC - 1));
  assign firing_o    = (state_q == WD_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      pulse_q <= '0;
    end else begin
      case (state_q)
        WD_FIRE: begin
          if (fire_done_o) begin
            state_q <= WD_IDLE;
            pulse_q <= '0;
          end else begin
            pulse_q <= pulse_q + PULSE_W'(1);
          end
        end
        default: begin
          if (feed) begin
            state_q <= WD_RUN;
            cnt_q   <= reload;
          end else if (timeout_o) begin
            state_q <= WD_FIRE;
            pulse_q <= '0;
          end else if (state_q == WD_RUN) begin
            cnt_q <= count_down(cnt_q);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned OFS_HI    = 0,
  parameter int unsigned OFS_LO    = 2,
  parameter int unsigned OFS_CLR   = 8,
  parameter logic [HALF_W-1:0] KEY_FIRST  = 'hF01E,
  parameter logic [HALF_W-1:0] KEY_SECOND = 'h0FE1,
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic              sys_rst_o,
  output logic              bus_rst_o
);

  localparam int unsigned RELOAD_W = 2 * HALF_W;

  logic                wr_ok;
  wd_wr_s              wr_dec;
  logic                feed_ok;
  logic                timeout_hit;
  logic                fire_done;
  logic                firing;
  logic [RELOAD_W-1:0] reload_val;

  assign wr_ok        = bus_wr && !firing;
  assign wr_dec.hi    = wr_ok && (bus_addr == ADDR_W'(OFS_HI));
  assign wr_dec.lo    = wr_ok && (bus_addr == ADDR_W'(OFS_LO));
  assign wr_dec.clr   = wr_ok && (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_dec.other = wr_ok && (bus_addr != ADDR_W'(OFS_CLR));

  wdog_reload_regs #(.HALF_W(HALF_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (wr_dec.hi),
    .wr_lo    (wr_dec.lo),
    .wdata    (bus_wdata),
    .wipe     (fire_done),
    .reload_o (reload_val)
  );

  wdog_feed_seq #(
    .HALF_W     (HALF_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) feed_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_clr   (wr_dec.clr),
    .wr_other (wr_dec.other),
    .wdata    (bus_wdata),
    .wipe     (fire_done),
    .feed_o   (feed_ok)
  );

  wdog_timer #(
    .RELOAD_W  (RELOAD_W),
    .PULSE_CYC (PULSE_CYC)
  ) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .feed        (feed_ok),
    .reload      (reload_val),
    .timeout_o   (timeout_hit),
    .firing_o    (firing),
    .fire_done_o (fire_done)
  );

  assign sys_rst_o = firing;
  assign bus_rst_o = firing;

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned OFS_CLR   = 8,
  parameter logic [HALF_W-1:0] KEY_FIRST  = 'hF01E,
  parameter logic [HALF_W-1:0] KEY_SECOND = 'h0FE1,
  parameter int unsigned PULSE_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [HALF_W-1:0] bus_wdata,
  input logic              sys_rst_o,
  input logic              bus_rst_o,
  input logic              feed_ok,
  input logic              timeout_hit,
  input logic              fire_done
);

  localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2);

  logic             fed_seen_q;
  logic             key_pend_q;
  logic [RUN_W-1:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fed_seen_q <= 1'b0;
      key_pend_q <= 1'b0;
      run_len_q  <= '0;
    end else begin
      if (feed_ok) fed_seen_q <= 1'b1;
      if (fire_done) key_pend_q <= 1'b0;
      else if (bus_wr && !sys_rst_o)
        key_pend_q <= (bus_addr == ADDR_W'(OFS_CLR)) && (bus_wdata == KEY_FIRST);
      run_len_q <= sys_rst_o ? run_len_q + RUN_W'(1) : '0;
    end
  end

  // R1: nothing fires before the first accepted feed
  assert_idle_until_fed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fed_seen_q |-> !sys_rst_o);

  // R4, R5: a feed needs the first key as the previous accepted write
  assert_key_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> (key_pend_q && bus_wr && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata == KEY_SECOND));

  // R3, R8: a completed feed never lets the outputs rise on the next edge
  assert_feed_holds_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> !sys_rst_o);

  // R6: outputs rise only from an expired count
  assert_rise_from_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(timeout_hit));

  // R9: both outputs always equal
  assert_outputs_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o == bus_rst_o);

  // R9: pulse never exceeds its length
  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (run_len_q < RUN_W'(PULSE_CYC)));

  // R9: pulse ends exactly at its length
  assert_pulse_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (run_len_q == RUN_W'(PULSE_CYC)));

  // R11: no feed is accepted during the pulse
  assert_pulse_blocks_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> !feed_ok);

endmodule

bind wdog_keyed wdog_keyed_chk #(
  .HALF_W     (HALF_W),
  .ADDR_W     (ADDR_W),
  .OFS_CLR    (OFS_CLR),
  .KEY_FIRST  (KEY_FIRST),
  .KEY_SECOND (KEY_SECOND),
  .PULSE_CYC  (PULSE_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .sys_rst_o   (sys_rst_o),
  .bus_rst_o   (bus_rst_o),
  .feed_ok     (feed_ok),
  .timeout_hit (timeout_hit),
  .fire_done   (fire_done)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;

  localparam int NVEC = 5;
  localparam logic [15:0] VEC_HI [NVEC] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0001};
  localparam logic [15:0] VEC_LO [NVEC] = '{16'h0000, 16'h0003, 16'h0080, 16'h03FF, 16'h0000};
  localparam int PULSE = 16;
  localparam int LIMIT = 70000;
  localparam int WDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        sys_rst_o;
  logic        bus_rst_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wdog_keyed dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sys_rst_o (sys_rst_o),
    .bus_rst_o (bus_rst_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYC) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WDOG_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int expect_cycles(input logic [15:0] hi, input logic [15:0] lo);
    return int'({hi, lo}) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic feed();
    wr(4'h8, 16'hF01E);
    wr(4'h8, 16'h0FE1);
  endtask

  task automatic wait_fire(output int n);
    n = 0;
    while (!sys_rst_o && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_len(output int n, output bit paired);
    n = 0; paired = 1'b1;
    while (sys_rst_o && n < 100) begin
      if (bus_rst_o !== sys_rst_o) paired = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_o || bus_rst_o) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  initial begin
    int c;
    int p;
    int r;
    bit pr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and idle until fed
    check(sys_rst_o == 1'b0 && bus_rst_o == 1'b0, "R1 reset outputs", int'(sys_rst_o), 0);
    quiet(60, "R1 idle without feed");

    // R6 R9 R10: table of timeouts, one loop
    for (int v = 0; v < NVEC; v++) begin
      wr(4'h0, VEC_HI[v]);
      wr(4'h2, VEC_LO[v]);
      feed();
      wait_fire(c);
      check(c == expect_cycles(VEC_HI[v], VEC_LO[v]), "R6 expiry edge", c, expect_cycles(VEC_HI[v], VEC_LO[v]));
      pulse_len(p, pr);
      check(p == PULSE && pr, "R9 pulse length and pairing", p, PULSE);
    end

    // R4: bare second key ignored (timeout is zero after the last pulse)
    wr(4'h8, 16'h0FE1);
    quiet(20, "R4 lone second key");

    // R5: foreign value discards pending first key
    wr(4'h8, 16'hF01E);
    wr(4'h8, 16'h1234);
    wr(4'h8, 16'h0FE1);
    quiet(20, "R5 foreign value between keys");

    // R5: write to reload offset discards pending first key
    wr(4'h8, 16'hF01E);
    wr(4'h2, 16'h0000);
    wr(4'h8, 16'h0FE1);
    quiet(20, "R5 reload write between keys");

    // R5: write to an unused offset discards pending first key
    wr(4'h8, 16'hF01E);
    wr(4'h4, 16'hF01E);
    wr(4'h8, 16'h0FE1);
    quiet(20, "R5 unused offset between keys");

    // R3 R7: keys separated by idle cycles, zero timeout fires next edge
    wr(4'h8, 16'hF01E);
    repeat (5) @(negedge clk);
    wr(4'h8, 16'h0FE1);
    wait_fire(c);
    check(c == 1, "R7 zero timeout with gapped feed R3", c, 1);
    pulse_len(p, pr);
    check(p == PULSE, "R9 pulse after zero timeout", p, PULSE);

    // R2: upper half only staged; old value used
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'h000A);
    wr(4'h0, 16'h0001);
    feed();
    wait_fire(c);
    check(c == 11, "R2 staged upper half not applied", c, 11);
    pulse_len(p, pr);

    // R8: periodic feeding holds off, then restart measured from last feed
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'd30);
    feed();
    for (int k = 0; k < 5; k++) begin
      quiet(20, "R8 fed periodically");
      feed();
    end
    wait_fire(c);
    check(c == 31, "R8 restart from last feed", c, 31);
    pulse_len(p, pr);

    // R10: idle after pulse, timeout cleared
    quiet(40, "R10 idle after pulse");
    feed();
    wait_fire(c);
    check(c == 1, "R10 timeout cleared to zero", c, 1);

    // R11: writes during pulse ignored, pulse length unchanged
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'd50);
    feed();
    pulse_len(r, pr);
    check(r == PULSE - 8, "R11 pulse not cut by feed", r + 8, PULSE);
    feed();
    wait_fire(c);
    check(c == 1, "R11 reload writes in pulse ignored", c, 1);
    pulse_len(p, pr);
    check(p == PULSE && pr, "R9 final pulse", p, PULSE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule